// File: doc/BRIEF.md
# Four-Lane Pipelined Integrator Cascade

This block is the integrating half of a cascaded integrator-comb decimator for a front end that delivers data at four times the clock rate. A single scalar integrator runs on the incoming signed sample stream. Its running sum is then fanned out unchanged onto four lanes. Feeding a held value to all four lanes is the same as integrating a stream that has been zero-stuffed by four, so the rest of the cascade works at four samples per clock.

Seven parallel integrator stages follow. Each one builds prefix sums across its four lanes with a chain of registered adders, and delay registers keep the later lanes aligned. The fed-back accumulator is added last, in a single step, so the feedback loop stays one register long while the rest of the stage is pipelined. All arithmetic is full precision at 43 bits and wraps in two's complement. A comb section downstream cancels the wraparound. The output is four running sums per clock, marked by a valid flag that travels through the pipeline with the data.

Top module: `intg_cascade4`

## Requirements
- R1: A synchronous active-high reset clears every accumulator, pipeline register and valid flag. While reset is held and on the first cycle after it, out_valid is 0 and every lane of out_lanes reads 0.
- R2: The front scalar integrator adds the sign-extended 14-bit input to its 43-bit sum only on cycles where in_valid is 1. On cycles where in_valid is 0 the sum is held.
- R3: The front integrator's sum is placed on all four lane inputs of the first parallel stage. The result equals integrating the input zero-stuffed by four, so a unit impulse gives lane values 1, 8, 36 and 120 in its first output group.
- R4: In each parallel stage, lane i (bits [43*i+42 : 43*i], lane 0 the earliest sample) equals the previous accumulator plus the sum of lanes 0 to i of the current group.
- R5: A parallel stage's accumulator moves forward by the sum of all four lanes once per valid group, and it does not change on groups that are not valid.
- R6: Each parallel stage adds exactly 4 cycles of latency. Overall, a sample accepted at one clock edge produces its output group with out_valid high 29 edges later (1 + 4*7).
- R7: All sums wrap modulo 2^43 with no saturation, truncation or rounding.
- R8: Whenever out_valid is 0, out_lanes keeps the value it had on the previous cycle.
- R9: For any input stream with any pattern of valid gaps, each output group matches eight cascaded scalar integrators applied to the zero-stuffed stream at four times the rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 14 | Signed input sample |
| out_valid | output | 1 | Marks an aligned output group |
| out_lanes | output | 172 | Four 43-bit running sums, lane 0 in the low bits |

## Verification
The bench drives a unit impulse and checks the binomial lane pattern. A design that copied the sum only to lane 0, or that added the accumulator before the prefix chain, would give the wrong lane shape or would double-count. The bench times the impulse from input to output to catch a missing or extra delay register in any lane. It then runs long full-scale positive and negative streams, which force many wraps; a design that saturated or was too narrow would drift from the wrapped reference. Randomly gapped traffic and a reset in mid-stream catch an accumulator that advances on invalid groups, outputs that change while out_valid is low, and stale groups that leak out after reset.

// File: rtl/intg_cascade_pkg.sv
package intg_cascade_pkg;
    localparam int DEF_IN_W   = 14;
    localparam int DEF_ACC_W  = 43;
    localparam int DEF_LANES  = 4;
    localparam int DEF_STAGES = 8;

    // Cycles from input edge to output group for a given shape.
    function automatic int cascade_latency(input int lanes, input int stages);
        return 1 + lanes * (stages - 1);
    endfunction
endpackage

// File: rtl/intg_scalar_stage.sv
module intg_scalar_stage #(
    parameter int IN_W  = 14,
    parameter int ACC_W = 43
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sample,
    output logic             out_valid,
    output logic [ACC_W-1:0] acc
);
    localparam int EXT_W = ACC_W - IN_W;

    logic [ACC_W-1:0] sample_ext;

    always_comb begin
        sample_ext = {{EXT_W{in_sample[IN_W-1]}}, in_sample};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc <= acc + sample_ext;
            end
        end
    end

    // R2: sum is frozen on idle input cycles
    p_scalar_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc));
endmodule

// File: rtl/intg_lane_stage.sv
module intg_lane_stage #(
    parameter int W     = 43,
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [LANES-1:0][W-1:0]   in_lanes,
    output logic                      out_valid,
    output logic [LANES-1:0][W-1:0]   out_lanes
);
    localparam int DEPTH = LANES - 1;
    localparam int CNT_W = $clog2(LANES + 1);

    // pipe[l] holds prefix sums through lane l+1; the other lanes are delayed copies
    logic [LANES-1:0][W-1:0] pipe  [DEPTH];
    logic [DEPTH-1:0]        pipe_v;
    logic [LANES-1:0][W-1:0] src   [DEPTH+1];
    logic [DEPTH:0]          src_v;

    always_comb begin
        src[0]   = in_lanes;
        src_v[0] = in_valid;
        for (int l = 0; l < DEPTH; l++) begin
            src[l+1]   = pipe[l];
            src_v[l+1] = pipe_v[l];
        end
    end

    // Adder chain: level l folds lane l into lane l+1
    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_v <= '0;
            for (int l = 0; l < DEPTH; l++) begin
                pipe[l] <= '0;
            end
        end else begin
            for (int l = 0; l < DEPTH; l++) begin
                pipe_v[l] <= src_v[l];
                for (int ln = 0; ln < LANES; ln++) begin
                    pipe[l][ln] <= src[l][ln] + ((ln == l + 1) ? src[l][l] : {W{1'b0}});
                end
            end
        end
    end

    // Feedback: the top lane is the accumulator and is added last on every lane
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_lanes <= '0;
        end else begin
            out_valid <= src_v[DEPTH];
            if (src_v[DEPTH]) begin
                for (int ln = 0; ln < LANES; ln++) begin
                    out_lanes[ln] <= out_lanes[LANES-1] + src[DEPTH][ln];
                end
            end
        end
    end

    // Cycles since reset, saturating; used only to arm the checks
    logic [CNT_W-1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != CNT_W'(LANES)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // R6: valid emerges exactly LANES cycles after it enters
    p_stage_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (since_rst == CNT_W'(LANES)) |-> (out_valid == $past(in_valid, LANES)));

    // R8 / R5: no output or accumulator movement on an invalid group
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (since_rst != '0 && !out_valid) |-> $stable(out_lanes));
endmodule

// File: rtl/intg_cascade4.sv
module intg_cascade4
    import intg_cascade_pkg::*;
#(
    parameter int IN_W   = DEF_IN_W,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int LANES  = DEF_LANES,
    parameter int STAGES = DEF_STAGES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [IN_W-1:0]          in_sample,
    output logic                     out_valid,
    output logic [LANES*ACC_W-1:0]   out_lanes
);
    localparam int PAR     = STAGES - 1;
    localparam int LATENCY = cascade_latency(LANES, STAGES);

    logic [ACC_W-1:0]                     front_sum;
    logic                                 front_v;
    logic [PAR:0][LANES-1:0][ACC_W-1:0]   chain;
    logic [PAR:0]                         chain_v;

    intg_scalar_stage #(
        .IN_W  (IN_W),
        .ACC_W (ACC_W)
    ) u_front (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (front_v),
        .acc       (front_sum)
    );

    // Holding one value on every lane is the zero-stuffed interpolation by LANES
    always_comb begin
        for (int ln = 0; ln < LANES; ln++) begin
            chain[0][ln] = front_sum;
        end
        chain_v[0] = front_v;
    end

    for (genvar s = 0; s < PAR; s++) begin : g_par
        intg_lane_stage #(
            .W     (ACC_W),
            .LANES (LANES)
        ) u_stage (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (chain_v[s]),
            .in_lanes  (chain[s]),
            .out_valid (chain_v[s+1]),
            .out_lanes (chain[s+1])
        );
    end

    assign out_valid = chain_v[PAR];
    assign out_lanes = chain[PAR];

    // R1: reset leaves an idle, zeroed output
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_lanes == '0));

    initial begin
        assert (LATENCY == 1 + LANES * PAR)
            else $error("latency mismatch");
    end
endmodule

// File: tb/test_intg_cascade4.sv
module test_intg_cascade4;
    localparam int IN_W   = 14;
    localparam int ACC_W  = 43;
    localparam int LANES  = 4;
    localparam int STAGES = 8;
    localparam int LAT    = 1 + LANES * (STAGES - 1);
    localparam int BUS_W  = LANES * ACC_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_sample = '0;
    logic             out_valid;
    logic [BUS_W-1:0] out_lanes;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    string cur_req = "R9";

    logic [BUS_W-1:0] exp_q [$];
    logic [ACC_W-1:0] ref_s [STAGES];
    logic [BUS_W-1:0] prev_out;
    logic             armed = 1'b0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    intg_cascade4 #(
        .IN_W   (IN_W),
        .ACC_W  (ACC_W),
        .LANES  (LANES),
        .STAGES (STAGES)
    ) i_intg_cascade4 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_lanes (out_lanes)
    );

    // Scalar reference: STAGES integrators on the zero-stuffed stream
    task automatic ref_push(input logic [IN_W-1:0] x);
        logic [BUS_W-1:0] item;
        logic [ACC_W-1:0] u;
        for (int j = 0; j < LANES; j++) begin
            u = (j == 0) ? {{(ACC_W-IN_W){x[IN_W-1]}}, x} : '0;
            ref_s[0] = ref_s[0] + u;
            for (int t = 1; t < STAGES; t++) ref_s[t] = ref_s[t] + ref_s[t-1];
            item[j*ACC_W +: ACC_W] = ref_s[STAGES-1];
        end
        exp_q.push_back(item);
    endtask

    task automatic ref_clear();
        for (int t = 0; t < STAGES; t++) ref_s[t] = '0;
        exp_q.delete();
    endtask

    task automatic check(input string req, input logic [BUS_W-1:0] act,
                         input logic [BUS_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [IN_W-1:0] x);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x;
        ref_push(x);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        idle();
        while (exp_q.size() != 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {out_valid, out_lanes}, '0);
        ref_clear();
        rst = 1'b0;
        @(negedge clk);
        check("R1", {out_valid, out_lanes}, '0);
    endtask

    function automatic longint binom(input int n, input int k);
        longint r;
        r = 1;
        for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
        return r;
    endfunction

    // Monitor: pop and compare each output group; check hold when idle
    always @(negedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    tests++;
                    fails++;
                    $display("FAIL %s unexpected output actual=%h expected=none", cur_req, out_lanes);
                end else begin
                    check(cur_req, out_lanes, exp_q.pop_front());
                end
            end else if (armed) begin
                check("R8", out_lanes, prev_out);
            end
            armed <= 1'b1;
        end
        prev_out <= out_lanes;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int c0;
        int guard;
        logic [BUS_W-1:0] imp;
        ref_clear();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {out_valid, out_lanes}, '0);
        rst = 1'b0;

        // R3 / R4 / R6: unit impulse, timing and lane shape
        cur_req = "R4";
        send(IN_W'(1));
        c0 = cyc;
        idle();
        guard = 0;
        while (!out_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        tests++;
        if (cyc - c0 != LAT) begin
            fails++;
            $display("FAIL R6 actual=%0d expected=%0d", cyc - c0, LAT);
        end
        for (int j = 0; j < LANES; j++) begin
            imp[j*ACC_W +: ACC_W] = ACC_W'(binom(j + STAGES - 1, STAGES - 1));
        end
        check("R3", out_lanes, imp);
        drain();

        // R2: negative full scale, then mixed signs
        do_reset();
        cur_req = "R2";
        for (int i = 0; i < 40; i++) send(14'h2000);
        for (int i = 0; i < 40; i++) send((i % 2 == 0) ? 14'h1FFF : 14'h3FF0);
        drain();

        // R7: long full-scale positive run forces many wraps
        do_reset();
        cur_req = "R7";
        for (int i = 0; i < 3000; i++) send(14'h1FFF);
        drain();

        // R5 / R9: random data with random gaps
        do_reset();
        cur_req = "R5";
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 2) == 0) idle();
            else send(IN_W'($urandom_range(0, 16383)));
        end
        drain();

        // R1: reset in mid-stream discards in-flight groups
        cur_req = "R9";
        for (int i = 0; i < 20; i++) send(IN_W'($urandom_range(0, 16383)));
        do_reset();
        repeat (LAT + 5) @(negedge clk);
        for (int i = 0; i < 50; i++) send(IN_W'($urandom_range(0, 16383)));
        drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule